// File: doc/BRIEF.md
# Cache Tag Window Port

This block exposes the tag and valid-bit storage of a direct-mapped instruction cache to software through a memory-mapped window. A bus master issues single 32-bit accesses. When the top address byte selects the window, the block decodes an entry index from the address and carries out one of three operations on that entry: a plain read, a direct write, or a conditional "associative" write. An associative write changes the valid bit only when the supplied tag matches a valid stored entry. Software can use it to invalidate one cached line by address without knowing whether that line is present.

The tag storage lives inside the block. A separate fill-side port lets the cache refill logic load entries. When both ports target the same entry in the same cycle, the bus port wins. Addresses are treated as physical; no translation happens on the associative path.

Every claimed request is answered by a registered response pulse one cycle later. A malformed access (misaligned or not a full word) gets an error response and changes nothing.

Top module: `tag_window_port`

## Requirements
- R1: A request is claimed only when req_addr[31:24] equals 0xF0. Any other address produces no response pulse and changes no entry.
- R2: The entry index is req_addr[12:5], which gives 256 entries. Address bits [23:13], [4] and [2] do not affect which entry is used.
- R3: A read returns the indexed entry as {3'b000, tag[18:0], 9'b0, valid} (tag in bits [28:10], valid in bit 0). The association bit req_addr[3] has no effect on reads.
- R4: A write with req_addr[3]=0 stores wdata[28:10] as the tag and wdata[0] as the valid bit, whatever the entry held before. wdata[31:29] and the reserved bits [9:1] are ignored.
- R5: A write with req_addr[3]=1 updates the valid bit to wdata[0] when wdata[28:10] equals the stored tag and the stored valid bit is 1. The stored tag is kept.
- R6: A write with req_addr[3]=1 leaves the entry unchanged when the tags differ or the stored valid bit is 0.
- R7: req_size encodes 0 as byte, 1 as halfword, 2 as word and 3 as reserved. A claimed access with req_size other than 2, or with req_addr[1:0] nonzero, is answered with rsp_err=1 and rsp_rdata=0, and leaves every entry unchanged.
- R8: Each claimed request raises rsp_ready for exactly one cycle, on the cycle after the request is sampled. Writes and error responses return rsp_rdata=0.
- R9: After reset every valid bit reads 0 and rsp_ready is 0.
- R10: A fill write (fill_we) loads fill_tag and fill_valid into entry fill_idx. The fill write is dropped if a well-formed bus write targets the same entry in the same cycle. Fill and bus writes to different entries both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data word |
| rsp_ready | output | 1 | One-cycle response pulse for a claimed request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data |
| fill_we | input | 1 | Fill-side write strobe |
| fill_idx | input | 8 | Fill-side entry index |
| fill_tag | input | 19 | Fill-side tag |
| fill_valid | input | 1 | Fill-side valid bit |

## Verification
Associative writes are tried against three kinds of stored entry: a valid entry with a matching tag, a matching but invalid entry, and a valid entry with a different tag. Only the first may change the valid bit. Reads are repeated with the association bit set, to show that reads never compare. Direct writes carry junk in the upper tag bits and reserved bits, to show that those bits are dropped. The same entry is reached through addresses that differ only in ignored bits, and the last index is exercised. Fill writes are issued alone, together with a bus write to the same entry, and together with a bus write to a different entry; this separates the bus-wins rule from a rule that would block all fills.

// File: rtl/tagwin_pkg.sv
package tagwin_pkg;
  localparam int          ADDR_W    = 32;
  localparam int          DATA_W    = 32;
  localparam int          SEL_LSB   = 24;
  localparam logic [7:0]  WIN_SEL   = 8'hF0;
  localparam int          IDX_LSB   = 5;
  localparam int          ASSOC_BIT = 3;
  localparam int          TAG_LSB   = 10;
  localparam int          VLD_BIT   = 0;
  localparam logic [1:0]  SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RD,
    OP_WR_PLAIN,
    OP_WR_ASSOC,
    OP_BAD
  } op_e;
endpackage

// File: rtl/tagwin_rst_sync.sv
module tagwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tagwin_decode.sv
module tagwin_decode
  import tagwin_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output op_e               op,
  output logic [IDX_W-1:0]  idx
);
  logic claim;
  logic well_formed;

  always_comb begin
    claim       = req_valid && (req_addr[ADDR_W-1:SEL_LSB] == WIN_SEL);
    well_formed = (req_addr[1:0] == 2'b00) && (req_size == SIZE_WORD);
    idx         = req_addr[IDX_LSB +: IDX_W];
    if (!claim)             op = OP_IDLE;
    else if (!well_formed)  op = OP_BAD;
    else if (!req_we)       op = OP_RD;
    else if (req_addr[ASSOC_BIT]) op = OP_WR_ASSOC;
    else                    op = OP_WR_PLAIN;
  end
endmodule

// File: rtl/tagwin_store.sv
module tagwin_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  input  logic             bus_touch,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic             bus_vld,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_vld
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] ent_en;
  logic             fill_go;

  always_comb begin
    fill_go = fill_we && !(bus_touch && (bus_idx == fill_idx));
    for (int i = 0; i < DEPTH; i++) begin
      ent_en[i] = 1'b0;
      tag_d[i]  = tag_q[i];
      vld_d[i]  = vld_q[i];
      if (bus_we && (bus_idx == IDX_W'(i))) begin
        ent_en[i] = 1'b1;
        tag_d[i]  = bus_tag;
        vld_d[i]  = bus_vld;
      end else if (fill_go && (fill_idx == IDX_W'(i))) begin
        ent_en[i] = 1'b1;
        tag_d[i]  = fill_tag;
        vld_d[i]  = fill_vld;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_en[i]) tag_q[i] <= tag_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_vld = vld_q[rd_idx];
endmodule

// File: rtl/tag_window_port.sv
module tag_window_port
  import tagwin_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_ready,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_valid
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  logic             rst_n_s;
  op_e              op;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_vld;
  logic [TAG_W-1:0] wr_tag;
  logic             wr_vld;
  logic             assoc_hit;
  logic             bus_touch;
  logic             bus_we;

  logic             rsp_ready_q, rsp_ready_d;
  logic             rsp_err_q,   rsp_err_d;
  logic [31:0]      rsp_rdata_q, rsp_rdata_d;

  tagwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  tagwin_decode #(.IDX_W(IDX_W)) u_dec (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .op        (op),
    .idx       (idx)
  );

  always_comb begin
    wr_tag    = req_wdata[TAG_MSB:TAG_LSB];
    wr_vld    = req_wdata[VLD_BIT];
    assoc_hit = rd_vld && (rd_tag == wr_tag);
    bus_touch = (op == OP_WR_PLAIN) || (op == OP_WR_ASSOC);
    bus_we    = (op == OP_WR_PLAIN) || ((op == OP_WR_ASSOC) && assoc_hit);
  end

  tagwin_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_idx    (idx),
    .rd_tag    (rd_tag),
    .rd_vld    (rd_vld),
    .bus_touch (bus_touch),
    .bus_we    (bus_we),
    .bus_idx   (idx),
    .bus_tag   (wr_tag),
    .bus_vld   (wr_vld),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag),
    .fill_vld  (fill_valid)
  );

  always_comb begin
    rsp_ready_d = (op != OP_IDLE);
    rsp_err_d   = (op == OP_BAD);
    rsp_rdata_d = '0;
    if (op == OP_RD) begin
      rsp_rdata_d[TAG_MSB:TAG_LSB] = rd_tag;
      rsp_rdata_d[VLD_BIT]         = rd_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_ready_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_ready_q <= rsp_ready_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_ready = rsp_ready_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/tagwin_chk.sv
module tagwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic [31:0] req_addr,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata
);
  AST_RSP_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> $past(req_valid && (req_addr[31:24] == 8'hF0))); // R1

  AST_BAD_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[31:24] == 8'hF0) &&
     ((req_addr[1:0] != 2'b00) || (req_size != 2'd2))) |=> (rsp_ready && rsp_err)); // R7

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ready && (rsp_rdata == 32'h0))); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> ((rsp_rdata[31:29] == 3'b000) && (rsp_rdata[9:1] == 9'h0))); // R3

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !$past(req_valid)) |-> 1'b0); // R8

  AST_CLAIM_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[31:24] == 8'hF0)) |=> rsp_ready); // R8
endmodule

bind tag_window_port tagwin_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/tag_window_port_tb_top.sv
module tag_window_port_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_we;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_ready;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        fill_we;
  logic [7:0]  fill_idx;
  logic [18:0] fill_tag;
  logic        fill_valid;

  int n_chk;
  int n_bad;
  bit done;

  tag_window_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_valid(fill_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req#(4), we(1), size(2), addr(32), wdata(32), exp_rdy(1), exp_err(1), exp_data(32)}
  localparam int NV = 18;
  localparam logic [104:0] VEC [NV] = '{
    {4'd4, 1'b1, 2'd2, 32'hF000_0060, 32'hE48D_1421, 1'b1, 1'b0, 32'h0000_0000}, // R4 junk in [31:29],[5]
    {4'd3, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1401}, // R3
    {4'd3, 1'b0, 2'd2, 32'hF000_0068, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1401}, // R3 assoc bit on read
    {4'd5, 1'b1, 2'd2, 32'hF000_0068, 32'h048D_1400, 1'b1, 1'b0, 32'h0000_0000}, // R5 hit, clear valid
    {4'd5, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1400}, // R5
    {4'd6, 1'b1, 2'd2, 32'hF000_0068, 32'h048D_1401, 1'b1, 1'b0, 32'h0000_0000}, // R6 stored invalid
    {4'd6, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1400}, // R6
    {4'd4, 1'b1, 2'd2, 32'hF000_0060, 32'h048D_1401, 1'b1, 1'b0, 32'h0000_0000}, // R4
    {4'd6, 1'b1, 2'd2, 32'hF000_0068, 32'h048D_1800, 1'b1, 1'b0, 32'h0000_0000}, // R6 tag mismatch
    {4'd6, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1401}, // R6
    {4'd1, 1'b1, 2'd2, 32'hE000_0060, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R1 not claimed
    {4'd1, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1401}, // R1
    {4'd7, 1'b1, 2'd2, 32'hF000_0061, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}, // R7 misaligned
    {4'd7, 1'b1, 2'd0, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}, // R7 byte size
    {4'd7, 1'b0, 2'd1, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}, // R7 halfword read
    {4'd7, 1'b0, 2'd2, 32'hF000_0060, 32'h0000_0000, 1'b1, 1'b0, 32'h048D_1401}, // R7 no state change
    {4'd2, 1'b1, 2'd2, 32'hF000_1FE0, 32'h1FFF_FC01, 1'b1, 1'b0, 32'h0000_0000}, // R2 last index
    {4'd2, 1'b0, 2'd2, 32'hF0FF_FFF4, 32'h0000_0000, 1'b1, 1'b0, 32'h1FFF_FC01}  // R2 ignored bits set
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the response sampled
  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, output logic rdy, output logic err,
                        output logic [31:0] rd);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; fill_we = 1'b0;
    rdy = rsp_ready; err = rsp_err; rd = rsp_rdata;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic r, e;
    logic [31:0] d;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_size = 2'd2;
    req_addr = '0; req_wdata = '0;
    fill_we = 1'b0; fill_idx = '0; fill_tag = '0; fill_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 rsp_ready after reset", {31'b0, rsp_ready}, 32'h0);
    access(1'b0, 2'd2, 32'hF000_0060, 32'h0, r, e, d);
    check("R9 valid bit idx3", {31'b0, d[0]}, 32'h0);
    access(1'b0, 2'd2, 32'hF000_1FE0, 32'h0, r, e, d);
    check("R9 valid bit idx255", {31'b0, d[0]}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [104:0] v;
      v = VEC[i];
      access(v[100], v[99:98], v[97:66], v[65:34], r, e, d);
      check($sformatf("R%0d vec%0d rdy/err", v[104:101], i), {30'b0, r, e}, {30'b0, v[33:32]});
      check($sformatf("R%0d vec%0d data", v[104:101], i), d, v[31:0]);
    end

    // R8 pulse is one cycle wide
    access(1'b0, 2'd2, 32'hF000_0060, 32'h0, r, e, d);
    check("R8 first cycle", {31'b0, r}, 32'h1);
    @(negedge clk);
    check("R8 pulse ends", {31'b0, rsp_ready}, 32'h0);

    // R10 fill alone into idx7
    fill_we = 1'b1; fill_idx = 8'd7; fill_tag = 19'h00ABC; fill_valid = 1'b1;
    @(negedge clk);
    fill_we = 1'b0;
    access(1'b0, 2'd2, 32'hF000_00E0, 32'h0, r, e, d);
    check("R10 fill load", d, 32'h002A_F001);

    // R10 collision: bus write wins on idx7
    fill_we = 1'b1; fill_idx = 8'd7; fill_tag = 19'h55555; fill_valid = 1'b1;
    access(1'b1, 2'd2, 32'hF000_00E0, 32'h0000_0401, r, e, d);
    access(1'b0, 2'd2, 32'hF000_00E0, 32'h0, r, e, d);
    check("R10 bus wins", d, 32'h0000_0401);

    // R10 different indices both land
    fill_we = 1'b1; fill_idx = 8'd9; fill_tag = 19'h00003; fill_valid = 1'b1;
    access(1'b1, 2'd2, 32'hF000_0100, 32'h0000_0801, r, e, d);
    access(1'b0, 2'd2, 32'hF000_0100, 32'h0, r, e, d);
    check("R10 bus idx8", d, 32'h0000_0801);
    access(1'b0, 2'd2, 32'hF000_0120, 32'h0, r, e, d);
    check("R10 fill idx9", d, 32'h0000_0C01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule